// File: doc/BRIEF.md
# Three-Chip Sound Generator Register Bridge

This bridge sits between a byte-wide host bus and three programmable sound generators on one board. The host sees four byte ports. Two of them hold a register pointer, one per directly attached chip (A and B). The other two move data to and from the register that pointer selects. A data write to a synthesis register becomes a one-cycle write strobe on that chip's interface. A write to the I/O port register is held locally inside the bridge. A read returns either the chip's register value or that local I/O register.

Chip C has no host port. Software reaches it by toggling bit 0 of chip B's I/O register, which acts as a strobe line. When that bit falls, the upper bits of the value written just before decide the action. One action loads chip A's I/O register into an internal pointer for chip C. The other sends chip A's I/O register as data to the chip C register that pointer selects. Any other combination leaves chip C alone.

Top module: `psg_trio_bridge`

## Requirements
- R1: A host write to offset 0 loads chip A's 8-bit register pointer, and a write to offset 1 loads chip B's. The low nibble of each pointer is shown on that chip's address output, and no strobe results.
- R2: A host write to offset 2 (chip A) or offset 3 (chip B) while that chip's pointer is below 0x0E raises the chip's write strobe for exactly the next cycle. The strobe carries the pointer's low nibble and the written byte. No other chip strobes.
- R3: A data write while the pointer equals 0x0F stores the byte in that chip's local I/O register and raises no strobe. A data write with the pointer at 0x0E or at 0x10 and above changes nothing.
- R4: Host read data is combinational. At offset 2 or 3 it is the chip's read input if the pointer is below 0x0E, the local I/O register if the pointer is 0x0F, and 0xFF otherwise. Offsets 0 and 1 read 0xFF.
- R5: Chip C is acted on only by a write of chip B's I/O register that takes bit 0 from 1 (the value held before the write) to 0 (the written value). A write that leaves bit 0 at 0, or takes it from 0 to 1, causes no chip C action.
- R6: On such a falling write, if the old value ANDed with 0xC2 equals 0x42, chip A's I/O register is copied into the chip C pointer.
- R7: On such a falling write, if the old value ANDed with 0xC2 equals 0x40 and the chip C pointer is below 0x0E, chip C's strobe rises for the next cycle. It carries the pointer's low nibble and chip A's current I/O register.
- R8: A falling write whose masked old value is neither 0x42 nor 0x40, or a data action while the chip C pointer is 0x0E or higher, raises no chip C strobe.
- R9: After each write of chip B's I/O register, that register holds the written byte. The next edge decision compares against it.
- R10: Reset clears all pointers and I/O registers to 0 and holds every strobe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write qualifier for this cycle |
| host_addr | input | 2 | Port offset 0..3 |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Combinational host read byte |
| a_we | output | 1 | Chip A register write strobe |
| a_addr | output | 4 | Chip A register select (pointer low nibble) |
| a_wdata | output | 8 | Chip A write byte |
| a_rdata | input | 8 | Chip A read value for a_addr |
| b_we | output | 1 | Chip B register write strobe |
| b_addr | output | 4 | Chip B register select |
| b_wdata | output | 8 | Chip B write byte |
| b_rdata | input | 8 | Chip B read value for b_addr |
| c_we | output | 1 | Chip C register write strobe |
| c_addr | output | 4 | Chip C register select |
| c_wdata | output | 8 | Chip C write byte |

## Verification
The hardest case to reach is a chip C data strobe. It needs a specific run of host writes: point both pointers at 0x0F, set chip A's I/O register, then write chip B's I/O register with a value that leaves bit 0 high and a masked pattern of 0x42. After that the bench drops bit 0, rewrites chip A's I/O register, and repeats the pattern with 0x40. The stimulus table plays these runs in full, along with near misses that must stay silent: a rising bit 0, masked value 0xC2, and a chip C pointer of 0x0E.

// File: rtl/psg_bridge_pkg.sv
package psg_bridge_pkg;
  localparam int DW  = 8;
  localparam int CAW = 4;
  localparam logic [DW-1:0] REG_LIMIT = 8'h0E;
  localparam logic [DW-1:0] IO_SEL    = 8'h0F;
  localparam logic [DW-1:0] RD_IDLE   = 8'hFF;
  localparam logic [DW-1:0] STB_MASK  = 8'hC2;
  localparam logic [DW-1:0] SEL_PTR   = 8'h42;
  localparam logic [DW-1:0] SEL_DATA  = 8'h40;

  typedef enum logic [1:0] {C_NONE, C_LATCH, C_DATA} c_op_t;

  function automatic logic is_reg(input logic [DW-1:0] a);
    return a < REG_LIMIT;
  endfunction

  function automatic logic is_io(input logic [DW-1:0] a);
    return a == IO_SEL;
  endfunction

  function automatic logic [DW-1:0] rd_pick(input logic [DW-1:0] a,
                                            input logic [DW-1:0] rdata,
                                            input logic [DW-1:0] io);
    if (is_reg(a)) return rdata;
    else if (is_io(a)) return io;
    else return RD_IDLE;
  endfunction

  function automatic c_op_t c_decode(input logic [DW-1:0] old_v,
                                     input logic [DW-1:0] new_v);
    logic [DW-1:0] m;
    m = old_v & STB_MASK;
    if (!(old_v[0] && !new_v[0])) return C_NONE;
    if (m == SEL_PTR)  return C_LATCH;
    if (m == SEL_DATA) return C_DATA;
    return C_NONE;
  endfunction
endpackage

// File: rtl/psg_direct_chan.sv
module psg_direct_chan
  import psg_bridge_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ptr_wr,
  input  logic           data_wr,
  input  logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  chip_rdata,
  output logic           chip_we,
  output logic [CAW-1:0] chip_addr,
  output logic [DW-1:0]  chip_wdata,
  output logic [DW-1:0]  rd_data,
  output logic [DW-1:0]  io_q,
  output logic           io_wr_ev
);
  logic [DW-1:0] ptr_q;
  logic [DW-1:0] wd_q;
  logic          we_q;
  logic          reg_wr_ev;

  assign io_wr_ev  = data_wr && is_io(ptr_q);
  assign reg_wr_ev = data_wr && is_reg(ptr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      io_q  <= '0;
      wd_q  <= '0;
      we_q  <= 1'b0;
    end else begin
      we_q <= reg_wr_ev;
      if (reg_wr_ev) wd_q  <= wdata;
      if (ptr_wr)    ptr_q <= wdata;
      if (io_wr_ev)  io_q  <= wdata;
    end
  end

  assign chip_we    = we_q;
  assign chip_addr  = ptr_q[CAW-1:0];
  assign chip_wdata = wd_q;
  assign rd_data    = rd_pick(ptr_q, chip_rdata, io_q);

  // R2: a strobe follows a data-port write one cycle earlier
  p_strobe_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chip_we |-> $past(data_wr));
  // R3: the I/O register moves only on its own write event
  p_io_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr_ev |=> $stable(io_q));
  // R9: the I/O register takes the written byte
  p_io_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr_ev |=> io_q == $past(wdata));
endmodule

// File: rtl/psg_indirect_ctrl.sv
module psg_indirect_ctrl
  import psg_bridge_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           b_io_wr,
  input  logic [DW-1:0]  b_io_old,
  input  logic [DW-1:0]  b_io_new,
  input  logic [DW-1:0]  a_io,
  output logic           c_we,
  output logic [CAW-1:0] c_addr,
  output logic [DW-1:0]  c_wdata,
  output logic           c_latch_ev,
  output logic           c_data_ev
);
  c_op_t         op;
  logic [DW-1:0] cptr_q;
  logic [DW-1:0] cwd_q;
  logic          cwe_q;

  assign op         = b_io_wr ? c_decode(b_io_old, b_io_new) : C_NONE;
  assign c_latch_ev = (op == C_LATCH);
  assign c_data_ev  = (op == C_DATA) && is_reg(cptr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cptr_q <= '0;
      cwd_q  <= '0;
      cwe_q  <= 1'b0;
    end else begin
      cwe_q <= c_data_ev;
      if (c_latch_ev) cptr_q <= a_io;
      if (c_data_ev)  cwd_q  <= a_io;
    end
  end

  assign c_we    = cwe_q;
  assign c_addr  = cptr_q[CAW-1:0];
  assign c_wdata = cwd_q;

  // R5: chip C acts only after a 1->0 write of bit 0
  p_c_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    c_we |-> ($past(b_io_wr) && $past(b_io_old[0]) && !$past(b_io_new[0])));
  // R6: pointer capture takes chip A's I/O value
  p_c_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    c_latch_ev |=> cptr_q == $past(a_io));
  // R8: no chip C strobe toward a pointer outside the register range
  p_c_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    c_we |-> is_reg(cptr_q));
  // R7: the strobe carries chip A's I/O value from the trigger cycle
  p_c_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c_we |-> c_wdata == $past(a_io));
endmodule

// File: rtl/psg_trio_bridge.sv
module psg_trio_bridge
  import psg_bridge_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_wr,
  input  logic [1:0]     host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           a_we,
  output logic [CAW-1:0] a_addr,
  output logic [DW-1:0]  a_wdata,
  input  logic [DW-1:0]  a_rdata,
  output logic           b_we,
  output logic [CAW-1:0] b_addr,
  output logic [DW-1:0]  b_wdata,
  input  logic [DW-1:0]  b_rdata,
  output logic           c_we,
  output logic [CAW-1:0] c_addr,
  output logic [DW-1:0]  c_wdata
);
  localparam int NPORT = 4;

  logic [NPORT-1:0] port_wr;
  logic [DW-1:0]    a_rd, b_rd, a_io, b_io;
  logic             a_io_ev, b_io_ev;
  logic             c_latch_ev, c_data_ev;

  for (genvar i = 0; i < NPORT; i++) begin : g_dec
    assign port_wr[i] = host_wr && (host_addr == i[1:0]);
  end

  psg_direct_chan u_chan_a (
    .clk(clk), .rst_n(rst_n), .ptr_wr(port_wr[0]), .data_wr(port_wr[2]),
    .wdata(host_wdata), .chip_rdata(a_rdata), .chip_we(a_we),
    .chip_addr(a_addr), .chip_wdata(a_wdata), .rd_data(a_rd),
    .io_q(a_io), .io_wr_ev(a_io_ev));

  psg_direct_chan u_chan_b (
    .clk(clk), .rst_n(rst_n), .ptr_wr(port_wr[1]), .data_wr(port_wr[3]),
    .wdata(host_wdata), .chip_rdata(b_rdata), .chip_we(b_we),
    .chip_addr(b_addr), .chip_wdata(b_wdata), .rd_data(b_rd),
    .io_q(b_io), .io_wr_ev(b_io_ev));

  psg_indirect_ctrl u_ctrl_c (
    .clk(clk), .rst_n(rst_n), .b_io_wr(b_io_ev), .b_io_old(b_io),
    .b_io_new(host_wdata), .a_io(a_io), .c_we(c_we), .c_addr(c_addr),
    .c_wdata(c_wdata), .c_latch_ev(c_latch_ev), .c_data_ev(c_data_ev));

  always_comb begin
    case (host_addr)
      2'd2:    host_rdata = a_rd;
      2'd3:    host_rdata = b_rd;
      default: host_rdata = RD_IDLE;
    endcase
  end

  // R2: one host write yields at most one strobe
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_we, b_we, c_we}));
  // R5: chip C events need a chip B I/O write
  p_c_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_latch_ev || c_data_ev) |-> (host_wr && host_addr == 2'd3 && b_io_ev));
  // R1: pointer writes never strobe
  p_ptr_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_addr[1]) |=> !(a_we || b_we || c_we));
  // R10: strobes are low in the cycle after reset
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> !(a_we || b_we || c_we));
endmodule

// File: tb/tb_psg_trio_bridge.sv
`timescale 1ns/1ps
module tb_psg_trio_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       a_we, b_we, c_we;
  logic [3:0] a_addr, b_addr, c_addr;
  logic [7:0] a_wdata, b_wdata, c_wdata, a_rdata, b_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // chip read models
  assign a_rdata = {4'h1, a_addr};
  assign b_rdata = {4'h2, b_addr};

  psg_trio_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata));

  // entry: offset, byte, strobes {a,b,c}, strobe addr, strobe data, req
  localparam int NV = 31;
  localparam logic [28:0] VEC [NV] = '{
    {2'd0, 8'h05, 3'b000, 4'h0, 8'h00, 4'd1},  // R1
    {2'd2, 8'h3C, 3'b100, 4'h5, 8'h3C, 4'd2},  // R2
    {2'd1, 8'h0D, 3'b000, 4'h0, 8'h00, 4'd1},  // R1
    {2'd3, 8'h77, 3'b010, 4'hD, 8'h77, 4'd2},  // R2
    {2'd0, 8'h0E, 3'b000, 4'h0, 8'h00, 4'd1},
    {2'd2, 8'h11, 3'b000, 4'h0, 8'h00, 4'd3},  // R3 ignored
    {2'd0, 8'h0F, 3'b000, 4'h0, 8'h00, 4'd1},
    {2'd2, 8'h09, 3'b000, 4'h0, 8'h00, 4'd3},  // R3 io store
    {2'd1, 8'h0F, 3'b000, 4'h0, 8'h00, 4'd1},
    {2'd3, 8'h01, 3'b000, 4'h0, 8'h00, 4'd5},  // R5 rising
    {2'd3, 8'h00, 3'b000, 4'h0, 8'h00, 4'd8},  // R8 mask 00
    {2'd3, 8'h43, 3'b000, 4'h0, 8'h00, 4'd5},
    {2'd3, 8'h42, 3'b000, 4'h0, 8'h00, 4'd6},  // R6 ptr=09
    {2'd2, 8'h5A, 3'b000, 4'h0, 8'h00, 4'd3},
    {2'd3, 8'h41, 3'b000, 4'h0, 8'h00, 4'd5},
    {2'd3, 8'h40, 3'b001, 4'h9, 8'h5A, 4'd7},  // R7
    {2'd3, 8'hC3, 3'b000, 4'h0, 8'h00, 4'd5},
    {2'd3, 8'hC2, 3'b000, 4'h0, 8'h00, 4'd8},  // R8 mask C2
    {2'd2, 8'h0E, 3'b000, 4'h0, 8'h00, 4'd3},
    {2'd3, 8'h43, 3'b000, 4'h0, 8'h00, 4'd5},
    {2'd3, 8'h42, 3'b000, 4'h0, 8'h00, 4'd6},  // R6 ptr=0E
    {2'd3, 8'h41, 3'b000, 4'h0, 8'h00, 4'd5},
    {2'd3, 8'h40, 3'b000, 4'h0, 8'h00, 4'd8},  // R8 ptr range
    {2'd2, 8'h02, 3'b000, 4'h0, 8'h00, 4'd3},
    {2'd3, 8'h43, 3'b000, 4'h0, 8'h00, 4'd5},
    {2'd3, 8'h42, 3'b000, 4'h0, 8'h00, 4'd6},  // R6 ptr=02
    {2'd2, 8'hA5, 3'b000, 4'h0, 8'h00, 4'd3},
    {2'd3, 8'h41, 3'b000, 4'h0, 8'h00, 4'd5},
    {2'd3, 8'h40, 3'b001, 4'h2, 8'hA5, 4'd7},  // R7
    {2'd3, 8'h41, 3'b000, 4'h0, 8'h00, 4'd5},  // R5 rising
    {2'd3, 8'h40, 3'b001, 4'h2, 8'hA5, 4'd7}   // R7 repeat
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] off, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = off; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] off, output logic [7:0] d);
    @(negedge clk);
    host_addr = off;
    #1 d = host_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [3:0] rq;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 strobes", {13'd0, a_we, b_we, c_we}, 16'h0000);
    host_read(2'd2, rd); chk("R10 A pointer zero", {8'h0, rd}, 16'h0010);
    host_read(2'd3, rd); chk("R10 B pointer zero", {8'h0, rd}, 16'h0020);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 strobes after release", {13'd0, a_we, b_we, c_we}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      host_write(VEC[i][28:27], VEC[i][26:19]);
      rq = VEC[i][3:0];
      checks++;
      if ({a_we, b_we, c_we} !== VEC[i][18:16]) begin
        errors++;
        $display("FAIL R%0d vec %0d strobes actual=%b expected=%b", rq, i,
                 {a_we, b_we, c_we}, VEC[i][18:16]);
      end else if (VEC[i][18:16] != 3'b000) begin
        logic [11:0] got;
        got = VEC[i][18] ? {a_addr, a_wdata} : VEC[i][17] ? {b_addr, b_wdata}
                                                          : {c_addr, c_wdata};
        if (got !== VEC[i][15:4]) begin
          errors++;
          $display("FAIL R%0d vec %0d addr/data actual=%h expected=%h", rq, i,
                   got, VEC[i][15:4]);
        end
      end
    end

    // R4 / R9: readback of I/O registers (both pointers at 0x0F)
    host_read(2'd2, rd); chk("R4 A io read", {8'h0, rd}, 16'h00A5);
    host_read(2'd3, rd); chk("R9 B io holds last write", {8'h0, rd}, 16'h0040);
    host_read(2'd0, rd); chk("R4 offset 0 idle", {8'h0, rd}, 16'h00FF);
    host_read(2'd1, rd); chk("R4 offset 1 idle", {8'h0, rd}, 16'h00FF);
    host_write(2'd0, 8'h03);
    host_read(2'd2, rd); chk("R4 A reg read", {8'h0, rd}, 16'h0013);
    host_write(2'd1, 8'h0B);
    host_read(2'd3, rd); chk("R4 B reg read", {8'h0, rd}, 16'h002B);
    host_write(2'd0, 8'h0E);
    host_read(2'd2, rd); chk("R4 pointer 0E reads FF", {8'h0, rd}, 16'h00FF);
    // R3: write at 0x0E ignored, I/O register untouched
    host_write(2'd2, 8'h66);
    chk("R3 no strobe at 0E", {13'd0, a_we, b_we, c_we}, 16'h0000);
    host_write(2'd0, 8'h20);
    host_read(2'd2, rd); chk("R4 pointer 20 reads FF", {8'h0, rd}, 16'h00FF);
    host_write(2'd2, 8'h77);
    chk("R3 no strobe at 20", {13'd0, a_we, b_we, c_we}, 16'h0000);
    host_write(2'd0, 8'h0F);
    host_read(2'd2, rd); chk("R3 A io unchanged", {8'h0, rd}, 16'h00A5);
    // R1: pointer nibble on chip address output
    host_write(2'd1, 8'h07);
    chk("R1 B address output", {12'd0, b_addr}, 16'h0007);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule